// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard unit of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at what the decode, execute, memory and writeback stages hold: a valid bit, the register numbers, and flags for load, data-memory access and register write. From these it produces four pipeline controls. It holds the program counter, holds the fetch/decode register, loads a NOP into the fetch/decode register, or loads a NOP into the decode/execute register. It also produces one operand-select per ALU source operand of the instruction in execute. The block is purely combinational. Its outputs act at the next clock edge of the pipeline registers they steer.

The timing it protects has one special feature. Non-load instructions write the register file during the memory stage, while loads write during writeback. A load followed at once by a register-writing ALU instruction would therefore hit the single write port twice in one cycle. The controller spaces these two instructions apart. The register file is assumed to complete a write before the read in the same cycle. A static forwarding enable picks between a bypassed and a non-bypassed pipeline. A static unified-memory input picks whether instruction fetch shares the single data-memory port.

Top module: `hzc_pipe_ctrl`

## Requirements
- R1: With forwarding on, a valid load in execute that writes a nonzero register equal to rs1 or rs2 of a valid decode instruction raises stall_fetch, stall_decode and bubble_execute for that cycle. The following cycle (load in memory, NOP in execute) raises no stall, so the pair sees exactly one bubble.
- R2: With forwarding off, a stall is raised in two cases: a valid register-writing instruction in execute whose destination equals a decode source, or a valid load in memory whose destination equals a decode source. A load-use pair therefore sees two bubbles and an ALU-use pair sees one. A non-load producer in memory causes no stall.
- R3: With forwarding on, a non-load producer in execute or memory, or a load already in memory or writeback, never causes a decode stall.
- R4: The operand select for the execute instruction uses 2'b00 for the register file, 2'b01 for the execute/memory value and 2'b10 for the memory/writeback value. fwd_sel_a serves rs1 and fwd_sel_b serves rs2. 2'b01 is chosen when a valid non-load writer in memory matches the source. 2'b10 is chosen when a valid load in writeback matches. When both match, the memory stage wins. A load in memory is never selected.
- R5: With forwarding off, or with the execute instruction invalid, both selects are 2'b00.
- R6: Register 0 never causes a data stall and is never forwarded.
- R7: In unified-memory mode, a valid data-memory access in the memory stage raises stall_fetch and bubble_decode, and decode advances. In split mode bubble_decode stays 0.
- R8: A valid load writing a register in execute, together with a valid non-load register writer in decode, raises stall_fetch, stall_decode and bubble_execute. This holds whatever the register numbers and the forwarding setting. A load in decode does not trigger this stall.
- R9: When a decode stall and a memory-port conflict coincide, stall_fetch, stall_decode and bubble_execute are 1 and bubble_decode is 0.
- R10: Invalid stages raise nothing: with all stages empty every output is 0, and an invalid execute producer causes no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| fwd_en | input | 1 | Static: 1 enables operand bypassing |
| unified_mem | input | 1 | Static: 1 means fetch shares the data-memory port |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_rs1 | input | REG_AW | Decode source register 1 |
| dec_rs2 | input | REG_AW | Decode source register 2 |
| dec_regwr | input | 1 | Decode instruction writes a register |
| dec_load | input | 1 | Decode instruction is a load |
| exe_valid | input | 1 | Execute stage holds a real instruction |
| exe_rs1 | input | REG_AW | Execute source register 1 |
| exe_rs2 | input | REG_AW | Execute source register 2 |
| exe_rd | input | REG_AW | Execute destination register |
| exe_load | input | 1 | Execute instruction is a load |
| exe_regwr | input | 1 | Execute instruction writes a register |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_access | input | 1 | Memory-stage instruction uses the data port |
| mem_regwr | input | 1 | Memory-stage instruction writes a register |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| wb_rd | input | REG_AW | Writeback destination register |
| wb_load | input | 1 | Writeback instruction is a load |
| wb_regwr | input | 1 | Writeback instruction writes a register |
| stall_fetch | output | 1 | Hold the program counter |
| bubble_decode | output | 1 | Load a NOP into the fetch/decode register |
| stall_decode | output | 1 | Hold the fetch/decode register |
| bubble_execute | output | 1 | Load a NOP into the decode/execute register |
| fwd_sel_a | output | 2 | Source select for ALU operand rs1 |
| fwd_sel_b | output | 2 | Source select for ALU operand rs2 |

## Verification
All outputs come from combinational logic, so a wrong decision appears at the ports in the same cycle as the stage contents that cause it. Missing the load-use or write-port condition shows up as a missing bubble_execute. The wrong priority between the memory and writeback stages shows up as 2'b10 where 2'b01 is due. A register-0 leak shows up as a stall or a nonzero select with every destination at 0. The scenarios include the two-cycle sequence of a non-bypassed load-use pair, both select priorities, and a data stall coinciding with a memory-port conflict.

// File: rtl/hzc_pkg.sv
// Package: shared types of the hazard controller.
// Assumes: operand selects are 2 bits wide and their codes are fixed by the datapath mux.
package hzc_pkg;

    // Operand source codes decoded by the ALU input multiplexers.
    typedef enum logic [1:0] {
        OPSEL_RF  = 2'b00,
        OPSEL_EXM = 2'b01,
        OPSEL_MWB = 2'b10
    } opsel_e;

endpackage

// File: rtl/hzc_reg_match.sv
// Module: compares one source register against one in-flight producer.
// Assumes: register 0 is hard-wired and is never a dependency.
module hzc_reg_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              prod_valid,
    input  logic              prod_wr,
    input  logic [REG_AW-1:0] prod_rd,
    output logic              hit
);

    // Raise hit when a live writer targets the nonzero source register.
    always_comb begin
        hit = prod_valid && prod_wr && (prod_rd != '0) && (prod_rd == src);
    end

endmodule

// File: rtl/hzc_dep_stall.sv
// Module: decides whether the decode instruction must wait for a producer.
// Assumes: register file writes complete before same-cycle reads; non-load
// results are written in the memory stage, load results in writeback.
module hzc_dep_stall #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic              fwd_en,
    input  logic              dec_valid,
    input  logic [REG_AW-1:0] dec_src [NUM_SRC],
    input  logic              exe_valid,
    input  logic              exe_regwr,
    input  logic              exe_load,
    input  logic [REG_AW-1:0] exe_rd,
    input  logic              mem_valid,
    input  logic              mem_regwr,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] mem_rd,
    output logic              dep_stall
);

    logic [NUM_SRC-1:0] hit_exe;
    logic [NUM_SRC-1:0] hit_mem;

    // One comparator pair per decode source operand.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        hzc_reg_match #(.REG_AW(REG_AW)) u_exe (
            .src        (dec_src[i]),
            .prod_valid (exe_valid),
            .prod_wr    (exe_regwr),
            .prod_rd    (exe_rd),
            .hit        (hit_exe[i])
        );
        hzc_reg_match #(.REG_AW(REG_AW)) u_mem (
            .src        (dec_src[i]),
            .prod_valid (mem_valid),
            .prod_wr    (mem_regwr),
            .prod_rd    (mem_rd),
            .hit        (hit_mem[i])
        );
    end

    logic ld_in_exe;
    logic ld_in_mem;

    // Combine hits into the bypassed and non-bypassed stall rules.
    always_comb begin
        ld_in_exe = (|hit_exe) && exe_load;
        ld_in_mem = (|hit_mem) && mem_load;
        if (fwd_en) begin
            dep_stall = dec_valid && ld_in_exe;
        end else begin
            dep_stall = dec_valid && ((|hit_exe) || ld_in_mem);
        end
    end

endmodule

// File: rtl/hzc_fwd_select.sv
// Module: picks the source of one ALU operand for the execute instruction.
// Assumes: a load in the memory stage never has a consumer in execute,
// because the decode stall already separated them.
module hzc_fwd_select
    import hzc_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              fwd_en,
    input  logic              exe_valid,
    input  logic [REG_AW-1:0] src,
    input  logic              mem_valid,
    input  logic              mem_regwr,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              wb_valid,
    input  logic              wb_regwr,
    input  logic              wb_load,
    input  logic [REG_AW-1:0] wb_rd,
    output opsel_e            sel
);

    logic hit_m;
    logic hit_w;

    hzc_reg_match #(.REG_AW(REG_AW)) u_m (
        .src        (src),
        .prod_valid (mem_valid),
        .prod_wr    (mem_regwr && !mem_load),
        .prod_rd    (mem_rd),
        .hit        (hit_m)
    );

    hzc_reg_match #(.REG_AW(REG_AW)) u_w (
        .src        (src),
        .prod_valid (wb_valid),
        .prod_wr    (wb_regwr && wb_load),
        .prod_rd    (wb_rd),
        .hit        (hit_w)
    );

    // Youngest producer first: memory stage, then writeback load.
    always_comb begin
        sel = OPSEL_RF;
        if (fwd_en && exe_valid) begin
            if (hit_m) begin
                sel = OPSEL_EXM;
            end else if (hit_w) begin
                sel = OPSEL_MWB;
            end
        end
    end

endmodule

// File: rtl/hzc_port_arbiter.sv
// Module: detects contention on the shared memory port and on the single
// register-file write port.
// Assumes: a write-port clash can only come from a load directly followed by
// a non-load writer, so it is caught while that pair sits in execute/decode.
module hzc_port_arbiter (
    input  logic unified_mem,
    input  logic mem_valid,
    input  logic mem_access,
    input  logic exe_valid,
    input  logic exe_load,
    input  logic exe_regwr,
    input  logic dec_valid,
    input  logic dec_load,
    input  logic dec_regwr,
    output logic mem_port_busy,
    output logic wport_clash
);

    // Fetch loses the port whenever the memory stage uses it.
    always_comb begin
        mem_port_busy = unified_mem && mem_valid && mem_access;
    end

    // Space a non-load writer one slot further behind a load.
    always_comb begin
        wport_clash = exe_valid && exe_load && exe_regwr &&
                      dec_valid && dec_regwr && !dec_load;
    end

endmodule

// File: rtl/hzc_pipe_ctrl.sv
// Module: top of the hazard and forwarding controller for a five-stage pipe.
// Assumes: stage flags come from the pipeline registers; fwd_en and
// unified_mem are static; a NOP is an instruction with its valid bit clear.
module hzc_pipe_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_en,
    input  logic              unified_mem,
    input  logic              dec_valid,
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic              dec_regwr,
    input  logic              dec_load,
    input  logic              exe_valid,
    input  logic [REG_AW-1:0] exe_rs1,
    input  logic [REG_AW-1:0] exe_rs2,
    input  logic [REG_AW-1:0] exe_rd,
    input  logic              exe_load,
    input  logic              exe_regwr,
    input  logic              mem_valid,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_load,
    input  logic              mem_access,
    input  logic              mem_regwr,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_load,
    input  logic              wb_regwr,
    output logic              stall_fetch,
    output logic              bubble_decode,
    output logic              stall_decode,
    output logic              bubble_execute,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b
);

    localparam int NUM_SRC = 2;

    logic [REG_AW-1:0] dec_src [NUM_SRC];
    logic [REG_AW-1:0] exe_src [NUM_SRC];
    opsel_e            op_sel  [NUM_SRC];
    logic              dep_stall;
    logic              mem_port_busy;
    logic              wport_clash;
    logic              hold_front;

    // Gather source operands into arrays for the replicated logic.
    always_comb begin
        dec_src[0] = dec_rs1;
        dec_src[1] = dec_rs2;
        exe_src[0] = exe_rs1;
        exe_src[1] = exe_rs2;
    end

    hzc_dep_stall #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_dep (
        .fwd_en    (fwd_en),
        .dec_valid (dec_valid),
        .dec_src   (dec_src),
        .exe_valid (exe_valid),
        .exe_regwr (exe_regwr),
        .exe_load  (exe_load),
        .exe_rd    (exe_rd),
        .mem_valid (mem_valid),
        .mem_regwr (mem_regwr),
        .mem_load  (mem_load),
        .mem_rd    (mem_rd),
        .dep_stall (dep_stall)
    );

    hzc_port_arbiter u_port (
        .unified_mem   (unified_mem),
        .mem_valid     (mem_valid),
        .mem_access    (mem_access),
        .exe_valid     (exe_valid),
        .exe_load      (exe_load),
        .exe_regwr     (exe_regwr),
        .dec_valid     (dec_valid),
        .dec_load      (dec_load),
        .dec_regwr     (dec_regwr),
        .mem_port_busy (mem_port_busy),
        .wport_clash   (wport_clash)
    );

    // One operand selector per ALU source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_opsel
        hzc_fwd_select #(.REG_AW(REG_AW)) u_sel (
            .fwd_en    (fwd_en),
            .exe_valid (exe_valid),
            .src       (exe_src[i]),
            .mem_valid (mem_valid),
            .mem_regwr (mem_regwr),
            .mem_load  (mem_load),
            .mem_rd    (mem_rd),
            .wb_valid  (wb_valid),
            .wb_regwr  (wb_regwr),
            .wb_load   (wb_load),
            .wb_rd     (wb_rd),
            .sel       (op_sel[i])
        );
    end

    // Merge hazard sources into pipeline register controls; a front hold wins
    // over a decode bubble because decode must keep its instruction.
    always_comb begin
        hold_front     = dep_stall || wport_clash;
        stall_fetch    = hold_front || mem_port_busy;
        stall_decode   = hold_front;
        bubble_execute = hold_front;
        bubble_decode  = mem_port_busy && !hold_front;
        fwd_sel_a      = op_sel[0];
        fwd_sel_b      = op_sel[1];
    end

    // R7
    split_mem_no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unified_mem |-> !bubble_decode);

    // R5
    fwd_off_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_en || !exe_valid) |-> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

    // R4
    sel_exm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a == 2'b01) |-> (mem_valid && mem_regwr && !mem_load && mem_rd == exe_rs1));

    // R4
    sel_mwb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_b == 2'b10) |-> (wb_valid && wb_load && wb_rd == exe_rs2));

    // R6
    r0_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_rs1 == '0) |-> (fwd_sel_a == 2'b00));

    // R9
    stall_over_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_decode |-> (stall_fetch && !bubble_decode));

    // R8
    wport_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_valid && exe_load && exe_regwr && dec_valid && dec_regwr && !dec_load)
            |-> (bubble_execute && stall_decode));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !mem_valid && !exe_valid)
            |-> (!stall_fetch && !bubble_decode && fwd_sel_a == 2'b00));

endmodule

// File: tb/hzc_pipe_ctrl_test.sv
module hzc_pipe_ctrl_test;

    localparam int AW = 5;
    localparam time TCK = 4ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_en, unified_mem;
    logic dec_valid, dec_regwr, dec_load;
    logic [AW-1:0] dec_rs1, dec_rs2;
    logic exe_valid, exe_load, exe_regwr;
    logic [AW-1:0] exe_rs1, exe_rs2, exe_rd;
    logic mem_valid, mem_load, mem_access, mem_regwr;
    logic [AW-1:0] mem_rd;
    logic wb_valid, wb_load, wb_regwr;
    logic [AW-1:0] wb_rd;
    logic stall_fetch, bubble_decode, stall_decode, bubble_execute;
    logic [1:0] fwd_sel_a, fwd_sel_b;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] want;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #(TCK/2) clk = ~clk;

    hzc_pipe_ctrl #(.REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .unified_mem(unified_mem),
        .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .dec_regwr(dec_regwr), .dec_load(dec_load),
        .exe_valid(exe_valid), .exe_rs1(exe_rs1), .exe_rs2(exe_rs2), .exe_rd(exe_rd),
        .exe_load(exe_load), .exe_regwr(exe_regwr),
        .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_load(mem_load),
        .mem_access(mem_access), .mem_regwr(mem_regwr),
        .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_load(wb_load), .wb_regwr(wb_regwr),
        .stall_fetch(stall_fetch), .bubble_decode(bubble_decode),
        .stall_decode(stall_decode), .bubble_execute(bubble_execute),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
    );

    // Advance one cycle and clear every stage to empty, bypass on, split memory.
    task automatic tick();
        @(posedge clk);
        #1;
        fwd_en = 1'b1; unified_mem = 1'b0;
        dec_valid = 0; dec_regwr = 0; dec_load = 0; dec_rs1 = '0; dec_rs2 = '0;
        exe_valid = 0; exe_load = 0; exe_regwr = 0; exe_rs1 = '0; exe_rs2 = '0; exe_rd = '0;
        mem_valid = 0; mem_load = 0; mem_access = 0; mem_regwr = 0; mem_rd = '0;
        wb_valid = 0; wb_load = 0; wb_regwr = 0; wb_rd = '0;
    endtask

    // Driver side of the scoreboard: expected {sf,bd,sd,be,sel_a,sel_b}.
    task automatic expect_out(input logic [7:0] want, input string tag);
        exp_t e;
        e.want = want;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare settled outputs mid-cycle against the queued item.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [7:0] got;
            e = sb_q.pop_front();
            got = {stall_fetch, bubble_decode, stall_decode, bubble_execute, fwd_sel_a, fwd_sel_b};
            checks++;
            if (got !== e.want) begin
                failures++;
                $display("FAIL %s got=%b expected=%b", e.tag, got, e.want);
            end
        end
    end

    initial begin
        #(TCK * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog got=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick();
        expect_out(8'b0000_0000, "R10 reset idle");
        tick();
        tick();
        rst_n = 1'b1;

        // R1 load-use on rs1
        tick(); exe_valid = 1; exe_load = 1; exe_regwr = 1; exe_rd = 3;
        dec_valid = 1; dec_rs1 = 3;
        expect_out(8'b1011_0000, "R1 load-use rs1");
        // R1 load-use on rs2
        tick(); exe_valid = 1; exe_load = 1; exe_regwr = 1; exe_rd = 3;
        dec_valid = 1; dec_rs2 = 3;
        expect_out(8'b1011_0000, "R1 load-use rs2");
        // R1/R3 second cycle: load in memory, NOP in execute
        tick(); mem_valid = 1; mem_load = 1; mem_regwr = 1; mem_rd = 3;
        dec_valid = 1; dec_rs1 = 3;
        expect_out(8'b0000_0000, "R3 load in mem no stall");
        // R4 writeback load forwarded
        tick(); wb_valid = 1; wb_load = 1; wb_regwr = 1; wb_rd = 3;
        exe_valid = 1; exe_rs1 = 3;
        expect_out(8'b0000_1000, "R4 wb load to rs1");
        // R3 ALU producer in execute
        tick(); exe_valid = 1; exe_regwr = 1; exe_rd = 4;
        dec_valid = 1; dec_rs1 = 4;
        expect_out(8'b0000_0000, "R3 alu in exe no stall");
        // R4 memory ALU forwarded to rs2
        tick(); mem_valid = 1; mem_regwr = 1; mem_rd = 4;
        exe_valid = 1; exe_rs2 = 4;
        expect_out(8'b0000_0001, "R4 mem alu to rs2");
        // R4 priority memory over writeback
        tick(); mem_valid = 1; mem_regwr = 1; mem_rd = 5;
        wb_valid = 1; wb_load = 1; wb_regwr = 1; wb_rd = 5;
        exe_valid = 1; exe_rs1 = 5; exe_rs2 = 5;
        expect_out(8'b0000_0101, "R4 youngest wins");
        // R4 load in memory not selected; R7 split mode ignores access
        tick(); mem_valid = 1; mem_load = 1; mem_regwr = 1; mem_access = 1; mem_rd = 6;
        exe_valid = 1; exe_rs1 = 6;
        expect_out(8'b0000_0000, "R4 R7 mem load split");
        // R6 register 0
        tick(); exe_valid = 1; exe_load = 1; exe_regwr = 1; exe_rd = 0;
        mem_valid = 1; mem_regwr = 1; mem_rd = 0;
        dec_valid = 1;
        expect_out(8'b0000_0000, "R6 reg zero");
        // R10 invalid execute producer
        tick(); exe_load = 1; exe_regwr = 1; exe_rd = 3;
        dec_valid = 1; dec_rs1 = 3;
        expect_out(8'b0000_0000, "R10 invalid exe");
        // R2 no bypass, ALU in execute
        tick(); fwd_en = 0; exe_valid = 1; exe_regwr = 1; exe_rd = 7;
        dec_valid = 1; dec_rs1 = 7;
        expect_out(8'b1011_0000, "R2 alu no bypass");
        // R2 no bypass, second load-use bubble
        tick(); fwd_en = 0; mem_valid = 1; mem_load = 1; mem_regwr = 1; mem_rd = 7;
        dec_valid = 1; dec_rs2 = 7;
        expect_out(8'b1011_0000, "R2 load second bubble");
        // R2 memory ALU no stall; R5 selects stay 00
        tick(); fwd_en = 0; mem_valid = 1; mem_regwr = 1; mem_rd = 7;
        dec_valid = 1; dec_rs1 = 7;
        wb_valid = 1; wb_load = 1; wb_regwr = 1; wb_rd = 8;
        exe_valid = 1; exe_rs1 = 7; exe_rs2 = 8;
        expect_out(8'b0000_0000, "R2 R5 no bypass");
        // R5 invalid execute, no select
        tick(); mem_valid = 1; mem_regwr = 1; mem_rd = 8; exe_rs1 = 8;
        expect_out(8'b0000_0000, "R5 exe invalid");
        // R7 unified store
        tick(); unified_mem = 1; mem_valid = 1; mem_access = 1;
        expect_out(8'b1100_0000, "R7 unified port");
        // R7 unified but empty memory stage
        tick(); unified_mem = 1; mem_access = 1;
        expect_out(8'b0000_0000, "R7 invalid mem");
        // R8 write-port spacing
        tick(); exe_valid = 1; exe_load = 1; exe_regwr = 1; exe_rd = 9;
        dec_valid = 1; dec_regwr = 1; dec_rs1 = 10; dec_rs2 = 11;
        expect_out(8'b1011_0000, "R8 wport clash");
        // R8 load behind load is fine
        tick(); exe_valid = 1; exe_load = 1; exe_regwr = 1; exe_rd = 9;
        dec_valid = 1; dec_regwr = 1; dec_load = 1; dec_rs1 = 10;
        expect_out(8'b0000_0000, "R8 load after load");
        // R8 also with bypass off
        tick(); fwd_en = 0; exe_valid = 1; exe_load = 1; exe_regwr = 1; exe_rd = 1;
        dec_valid = 1; dec_regwr = 1; dec_rs1 = 2; dec_rs2 = 3;
        expect_out(8'b1011_0000, "R8 no bypass clash");
        // R9 data stall with port conflict
        tick(); unified_mem = 1; mem_valid = 1; mem_access = 1; mem_load = 1;
        mem_regwr = 1; mem_rd = 12;
        exe_valid = 1; exe_load = 1; exe_regwr = 1; exe_rd = 9;
        dec_valid = 1; dec_rs1 = 9;
        expect_out(8'b1011_0000, "R9 stall wins");

        tick();
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule